// File: doc/BRIEF.md
# Partitioned Parallel Term Matcher

This block scans a character stream for a set of search terms. The work is spread over a row of small partitions that run in parallel. Each partition holds a private table of states. An active partition tests one character per state and either advances to a programmed next state or drops out. Each partition reads its table exactly once for every accepted character, so throughput is one character per clock regardless of how many terms are loaded.

A branch in a term is not stored as a multi-way row. Instead, a state that matches can push a second thread into an idle neighbour partition. A startup table starts a new attempt at each word start. The table is indexed by the first character of the word, so the attempt begins on the second character and attempts that would die on the first character never start. A state can test for an exact character, for a character with the case bit ignored, or for a character class. A state can also wait in place over an arbitrary run of word characters. Terminal states report a term identifier through a small queue that reports simultaneous hits from the lowest partition upward.

A host loads the state tables and the startup table through a single write port before streaming text. Compiling terms into partitions is done outside the block.

Top module: `pfsa_term_matcher`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `hit_valid` is 0 and every partition is idle. After reset the next accepted character counts as the start of a word.
- R2: A start happens only for a word character accepted right after a delimiter, or as the first character after reset. The startup entry indexed by that character has this layout: bit 0 is the enable, bits [3:1] are the partition, and bits [8:4] are the state address. If the entry is enabled, that partition becomes active at that address and tests the next character. Characters in the middle of a word never start anything.
- R3: The state word packs these fields, LSB first: pattern [7:0], mode [9:8], next address [14:10], fork enable [15], fork partition [18:16], fork address [23:19], terminal [24], term ID [32:25]. If an active state hits, the partition moves to the next address, and a next address of 0 makes it idle. If the state misses, the partition goes idle, except as set out in R4.
- R4: The mode codes are: 0 for exact compare; 1 for compare with bit 5 (0x20) ignored; 2 for class, where pattern[1:0] selects 0 digit, 1 letter or 2 delimiter; and 3 for run. A run state hits on an exact compare. It stays in place on any other word character and goes idle on a delimiter.
- R5: When a state with fork enable set hits, the fork partition is loaded with the fork address. That partition tests the following character in parallel with the forking partition.
- R6: When a state with the terminal flag set hits, its term ID is queued for output.
- R7: Term IDs leave one per cycle on `hit_term`, with `hit_valid` high for one cycle per ID. IDs queued in the same cycle leave lowest partition first. No ID is lost or repeated while the queue is not full.
- R8: A cycle with `chr_valid` low changes no partition state and creates no new report, whatever `chr_data` holds.
- R9: A delimiter is any character outside 0-9, A-Z and a-z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_valid | input | 1 | A character is presented this cycle |
| chr_data | input | 8 | Stream character |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | 0 writes a partition state table, 1 writes the startup table |
| cfg_part | input | 3 | Partition selected for a state write |
| cfg_addr | input | 8 | State address (low 5 bits) or startup index (character) |
| cfg_data | input | 33 | State word, or startup entry in the low 9 bits |
| hit_valid | output | 1 | A term ID is reported this cycle |
| hit_term | output | 8 | Reported term ID |

## Verification
The bench uses the default parameters: eight partitions, 32 states each and an eight-entry report queue. Its program occupies six partitions. With it, one word such as "dog" produces two terminals in the same cycle in partitions 0 and 1, and then a fork-launched whole-word check in partition 5. This exercises the ordering of simultaneous hits and a fork out of a terminal state. The 5-bit state addresses are wide enough to hold the multi-state terms and the run state used to cover an embedded don't-care. Random streams drawn from a word list that hits each term, with idle gaps mixed in, are checked against a reference model of the terms.

// File: rtl/pfsa_pkg.sv
package pfsa_pkg;
  localparam int CHW = 8;

  typedef enum logic [1:0] {
    CMP_EXACT = 2'd0,
    CMP_FOLD  = 2'd1,
    CMP_CLASS = 2'd2,
    CMP_RUN   = 2'd3
  } cmp_mode_e;

  localparam logic [1:0] CLS_DIGIT = 2'd0;
  localparam logic [1:0] CLS_ALPHA = 2'd1;
  localparam logic [1:0] CLS_DELIM = 2'd2;

  function automatic logic is_digit(input logic [CHW-1:0] c);
    return (c >= 8'h30) && (c <= 8'h39);
  endfunction

  function automatic logic is_alpha(input logic [CHW-1:0] c);
    return ((c >= 8'h41) && (c <= 8'h5A)) || ((c >= 8'h61) && (c <= 8'h7A));
  endfunction

  function automatic logic is_delim(input logic [CHW-1:0] c);
    return !(is_digit(c) || is_alpha(c));
  endfunction

  // One comparison per state: exact, case-folded, or class membership.
  function automatic logic char_hit(input cmp_mode_e m, input logic [CHW-1:0] pat,
                                    input logic [CHW-1:0] c);
    logic r;
    case (m)
      CMP_FOLD:  r = ((c | 8'h20) == (pat | 8'h20));
      CMP_CLASS: begin
        case (pat[1:0])
          CLS_DIGIT: r = is_digit(c);
          CLS_ALPHA: r = is_alpha(c);
          CLS_DELIM: r = is_delim(c);
          default:   r = 1'b0;
        endcase
      end
      default:   r = (c == pat);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pfsa_partition.sv
module pfsa_partition import pfsa_pkg::*; #(
  parameter int SAW  = 5,
  parameter int PW   = 3,
  parameter int TIDW = 8,
  localparam int WW    = CHW + 2 + SAW + 1 + PW + SAW + 1 + TIDW,
  localparam int DEPTH = 1 << SAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [SAW-1:0]  cfg_addr,
  input  logic [WW-1:0]   cfg_word,
  input  logic            ch_valid,
  input  logic [CHW-1:0]  ch,
  input  logic            ld_en,
  input  logic [SAW-1:0]  ld_addr,
  output logic            act,
  output logic [SAW-1:0]  cur,
  output logic            rep,
  output logic [TIDW-1:0] rep_id,
  output logic            fork_req,
  output logic [PW-1:0]   fork_part,
  output logic [SAW-1:0]  fork_addr
);
  localparam int O_MODE  = CHW;
  localparam int O_NXT   = O_MODE + 2;
  localparam int O_FEN   = O_NXT + SAW;
  localparam int O_FPART = O_FEN + 1;
  localparam int O_FADDR = O_FPART + PW;
  localparam int O_TERM  = O_FADDR + SAW;
  localparam int O_TID   = O_TERM + 1;

  logic [WW-1:0] tbl [DEPTH];
  logic [WW-1:0] word;
  cmp_mode_e     mode;
  logic [SAW-1:0] nxt;
  logic          hit, stay, cont;
  logic [SAW-1:0] cont_addr;

  always_ff @(posedge clk) begin
    if (cfg_we) tbl[cfg_addr] <= cfg_word;
  end

  assign word = tbl[cur];
  assign mode = cmp_mode_e'(word[O_MODE +: 2]);
  assign nxt  = word[O_NXT +: SAW];

  always_comb begin
    hit       = act && ch_valid && char_hit(mode, word[CHW-1:0], ch);
    stay      = act && ch_valid && !hit && (mode == CMP_RUN) && !is_delim(ch);
    cont      = (hit && (nxt != '0)) || stay;
    cont_addr = hit ? nxt : cur;
  end

  assign rep       = hit && word[O_TERM];
  assign rep_id    = word[O_TID +: TIDW];
  assign fork_req  = hit && word[O_FEN];
  assign fork_part = word[O_FPART +: PW];
  assign fork_addr = word[O_FADDR +: SAW];

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      cur <= '0;
    end else if (ch_valid) begin
      if (cont) begin
        act <= 1'b1;
        cur <= cont_addr;
      end else if (ld_en) begin
        act <= 1'b1;
        cur <= ld_addr;
      end else begin
        act <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfsa_startup.sv
module pfsa_startup import pfsa_pkg::*; #(
  parameter int SAW = 5,
  parameter int PW  = 3,
  localparam int EW   = 1 + PW + SAW,
  localparam int NENT = 1 << CHW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_addr,
  input  logic [EW-1:0]  cfg_entry,
  input  logic           ch_valid,
  input  logic [CHW-1:0] ch,
  output logic           st_en,
  output logic [PW-1:0]  st_part,
  output logic [SAW-1:0] st_addr
);
  logic [EW-1:0] tbl [NENT];
  logic [EW-1:0] ent;
  logic          at_word_start;

  always_ff @(posedge clk) begin
    if (cfg_we) tbl[cfg_addr] <= cfg_entry;
  end

  assign ent     = tbl[ch];
  assign st_en   = ch_valid && at_word_start && ent[0] && !is_delim(ch);
  assign st_part = ent[1 +: PW];
  assign st_addr = ent[1+PW +: SAW];

  always_ff @(posedge clk) begin
    if (rst)           at_word_start <= 1'b1;
    else if (ch_valid) at_word_start <= is_delim(ch);
  end
endmodule

// File: rtl/pfsa_hit_fifo.sv
module pfsa_hit_fifo #(
  parameter int NPART = 8,
  parameter int TIDW  = 8,
  parameter int FAW   = 3,
  localparam int DEPTH = 1 << FAW,
  localparam int LW    = FAW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPART-1:0]      push,
  input  logic [NPART*TIDW-1:0] push_ids,
  output logic                  out_valid,
  output logic [TIDW-1:0]       out_id,
  output logic [LW-1:0]         level
);
  logic [TIDW-1:0] mem [DEPTH];
  logic [FAW-1:0]  wptr, rptr;
  logic [NPART-1:0] acc;
  logic [FAW-1:0]  widx [NPART];
  logic [LW-1:0]   nacc;
  logic            pop;

  // Each accepted report takes the slot after all lower-numbered ones.
  always_comb begin
    int run;
    int free;
    run  = 0;
    free = DEPTH - int'(level);
    for (int i = 0; i < NPART; i++) begin
      acc[i]  = push[i] && (run < free);
      widx[i] = wptr + FAW'(run);
      if (push[i]) run++;
    end
    nacc = (run < free) ? LW'(run) : LW'(free);
  end

  assign pop = (level != '0);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPART; i++) begin
      if (acc[i]) mem[widx[i]] <= push_ids[i*TIDW +: TIDW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      level     <= '0;
      out_valid <= 1'b0;
      out_id    <= '0;
    end else begin
      wptr      <= wptr + FAW'(nacc);
      rptr      <= rptr + FAW'(pop);
      level     <= level + nacc - LW'(pop);
      out_valid <= pop;
      if (pop) out_id <= mem[rptr];
    end
  end
endmodule

// File: rtl/pfsa_term_matcher.sv
module pfsa_term_matcher import pfsa_pkg::*; #(
  parameter int NPART = 8,
  parameter int SAW   = 5,
  parameter int TIDW  = 8,
  parameter int FAW   = 3,
  localparam int PW = $clog2(NPART),
  localparam int WW = CHW + 2 + SAW + 1 + PW + SAW + 1 + TIDW,
  localparam int EW = 1 + PW + SAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            chr_valid,
  input  logic [CHW-1:0]  chr_data,
  input  logic            cfg_we,
  input  logic            cfg_tbl,
  input  logic [PW-1:0]   cfg_part,
  input  logic [7:0]      cfg_addr,
  input  logic [WW-1:0]   cfg_data,
  output logic            hit_valid,
  output logic [TIDW-1:0] hit_term
);
  logic [NPART-1:0]      act_vec, rep_vec, freq_vec, ld_vec, fork_into, st_vec;
  logic [SAW-1:0]        cur_a [NPART];
  logic [SAW-1:0]        fa    [NPART];
  logic [SAW-1:0]        ld_a  [NPART];
  logic [PW-1:0]         fp    [NPART];
  logic [NPART*TIDW-1:0] ids_flat;
  logic [NPART*SAW-1:0]  addr_flat;
  logic                  st_en;
  logic [PW-1:0]         st_part;
  logic [SAW-1:0]        st_addr;
  logic [FAW:0]          fifo_level;

  pfsa_startup #(.SAW(SAW), .PW(PW)) u_start (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we && cfg_tbl), .cfg_addr(cfg_addr), .cfg_entry(cfg_data[EW-1:0]),
    .ch_valid(chr_valid), .ch(chr_data),
    .st_en(st_en), .st_part(st_part), .st_addr(st_addr)
  );

  for (genvar p = 0; p < NPART; p++) begin : g_part
    pfsa_partition #(.SAW(SAW), .PW(PW), .TIDW(TIDW)) u_part (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_we && !cfg_tbl && (cfg_part == PW'(p))),
      .cfg_addr(cfg_addr[SAW-1:0]), .cfg_word(cfg_data),
      .ch_valid(chr_valid), .ch(chr_data),
      .ld_en(ld_vec[p]), .ld_addr(ld_a[p]),
      .act(act_vec[p]), .cur(cur_a[p]),
      .rep(rep_vec[p]), .rep_id(ids_flat[p*TIDW +: TIDW]),
      .fork_req(freq_vec[p]), .fork_part(fp[p]), .fork_addr(fa[p])
    );
    assign addr_flat[p*SAW +: SAW] = cur_a[p];
  end

  // Fork routing (lowest source wins), then startup into the same load port.
  always_comb begin
    for (int p = 0; p < NPART; p++) begin
      fork_into[p] = 1'b0;
      ld_a[p]      = '0;
      for (int q = NPART - 1; q >= 0; q--) begin
        if (freq_vec[q] && (fp[q] == PW'(p))) begin
          fork_into[p] = 1'b1;
          ld_a[p]      = fa[q];
        end
      end
      st_vec[p] = st_en && (st_part == PW'(p));
      if (!fork_into[p] && st_vec[p]) ld_a[p] = st_addr;
      ld_vec[p] = fork_into[p] || st_vec[p];
    end
  end

  pfsa_hit_fifo #(.NPART(NPART), .TIDW(TIDW), .FAW(FAW)) u_fifo (
    .clk(clk), .rst(rst),
    .push(rep_vec), .push_ids(ids_flat),
    .out_valid(hit_valid), .out_id(hit_term), .level(fifo_level)
  );
endmodule

// File: rtl/pfsa_chk.sv
module pfsa_chk #(
  parameter int NPART = 8,
  parameter int SAW   = 5,
  parameter int FAW   = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 chr_valid,
  input logic                 hit_valid,
  input logic [NPART-1:0]     act_vec,
  input logic [NPART*SAW-1:0] addr_flat,
  input logic [NPART-1:0]     fork_into,
  input logic [NPART-1:0]     st_vec,
  input logic [FAW:0]         fifo_level
);
  localparam int DEPTH = 1 << FAW;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!hit_valid && (act_vec == '0)));

  a_r8_frozen_when_idle: assert property (@(posedge clk) disable iff (rst)
    !chr_valid |=> ($stable(act_vec) && $stable(addr_flat)));

  a_r5_fork_into_idle: assert property (@(posedge clk) disable iff (rst)
    chr_valid |-> ((fork_into & act_vec) == '0));

  a_r2_start_into_idle: assert property (@(posedge clk) disable iff (rst)
    chr_valid |-> ((st_vec & act_vec) == '0));

  a_r7_queue_bound: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= (FAW+1)'(DEPTH));

  a_r7_out_from_queue: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> ($past(fifo_level) != '0));
endmodule

bind pfsa_term_matcher pfsa_chk #(.NPART(NPART), .SAW(SAW), .FAW(FAW)) u_chk (
  .clk(clk), .rst(rst), .chr_valid(chr_valid), .hit_valid(hit_valid),
  .act_vec(act_vec), .addr_flat(addr_flat), .fork_into(fork_into),
  .st_vec(st_vec), .fifo_level(fifo_level)
);

// File: tb/pfsa_term_matcher_tb.sv
module pfsa_term_matcher_tb;
  localparam int NPART = 8, SAW = 5, TIDW = 8, FAW = 3;
  localparam int PW = 3;
  localparam int WW = 8 + 2 + SAW + 1 + PW + SAW + 1 + TIDW;

  logic clk = 1'b0, rst = 1'b1;
  logic chr_valid = 1'b0;
  logic [7:0] chr_data = 8'h0;
  logic cfg_we = 1'b0, cfg_tbl = 1'b0;
  logic [PW-1:0] cfg_part = '0;
  logic [7:0] cfg_addr = '0;
  logic [WW-1:0] cfg_data = '0;
  logic hit_valid;
  logic [TIDW-1:0] hit_term;

  always #2.5 clk = ~clk;

  pfsa_term_matcher #(.NPART(NPART), .SAW(SAW), .TIDW(TIDW), .FAW(FAW)) u_dut (
    .clk(clk), .rst(rst), .chr_valid(chr_valid), .chr_data(chr_data),
    .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_part(cfg_part), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .hit_valid(hit_valid), .hit_term(hit_term)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int unsigned exp_q[$];
  string tag_q[$];
  string cur_tag = "R1";

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model state: current word position and first three characters.
  int wl = 0;
  byte w0, w1, w2;

  function automatic bit m_digit(byte c); return c >= "0" && c <= "9"; endfunction
  function automatic bit m_alpha(byte c);
    return (c >= "A" && c <= "Z") || (c >= "a" && c <= "z");
  endfunction
  function automatic bit m_delim(byte c); return !(m_digit(c) || m_alpha(c)); endfunction

  function automatic void expect_id(int unsigned id, string tag);
    exp_q.push_back(id);
    tag_q.push_back(tag);
  endfunction

  // Expected reports for one accepted character, lowest partition first (R7).
  function automatic void model(byte c);
    int pos;
    if (m_delim(c)) begin
      if (wl == 3 && w0 == "d" && w1 == "o" && w2 == "g") expect_id(8'h77, "R5 fork+delim class R9");
      wl = 0;
      return;
    end
    pos = wl;
    if (pos == 0) w0 = c; else if (pos == 1) w1 = c; else if (pos == 2) w2 = c;
    wl++;
    if (pos == 2 && w0 == "d" && w1 == "o") begin
      if (c == "g") expect_id(8'h51, "R3 exact chain R6");
      if (m_alpha(c)) expect_id(8'h22, "R4 letter class after fork R5");
    end
    if (pos == 2 && (w0 | 8'h20) == "c" && (w1 | 8'h20) == "a" && (c | 8'h20) == "b")
      expect_id(8'h33, "R4 case fold");
    if (pos == 1 && w0 == "x" && m_digit(c)) expect_id(8'h40, "R4 digit class");
    if (pos >= 1 && w0 == "b" && c == "y") expect_id(8'h66, "R4 run state");
  endfunction

  always @(negedge clk) begin
    if (!rst && hit_valid && !done) begin
      if (exp_q.size() == 0) begin
        check(0, {cur_tag, " R7 unexpected report"}, hit_term, 0);
      end else begin
        check(hit_term == exp_q[0], {tag_q[0], " R7 order"}, hit_term, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic send_char(byte c);
    model(c);
    chr_valid = 1'b1;
    chr_data  = c;
    @(negedge clk);
    chr_valid = 1'b0;
  endtask

  task automatic send_str(string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) begin
      chr_data = "d";
      @(negedge clk);
    end
  endtask

  task automatic drained(string tag);
    gap(12);
    check(exp_q.size() == 0, {tag, " all expected reports seen"}, exp_q.size(), 0);
  endtask

  function automatic logic [WW-1:0] sw(byte pat, logic [1:0] md, int nxt, bit fen,
                                       int fpart, int faddr, bit term, logic [7:0] tid);
    return {tid, term, 5'(faddr), 3'(fpart), fen, 5'(nxt), md, pat};
  endfunction

  task automatic wr_state(int part, int addr, logic [WW-1:0] w);
    cfg_we = 1'b1; cfg_tbl = 1'b0; cfg_part = PW'(part); cfg_addr = 8'(addr); cfg_data = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_start(byte c, int part, int addr, bit en);
    cfg_we = 1'b1; cfg_tbl = 1'b1; cfg_part = '0; cfg_addr = c;
    cfg_data = WW'({5'(addr), 3'(part), en});
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    string words[12] = '{"dog", "dot", "do", "cab", "CaB", "x5", "x", "baby", "byy", "bad", "dogs", "xx"};
    string alph = "dogtcCaAbByx07 -.";
    string seps = " -.";
    int unsigned seed;
    seed = $urandom(32'd7321);

    // Clear every table entry that the program leaves unused.
    for (int a = 0; a < 256; a++) wr_start(byte'(a), 0, 0, 0);
    for (int p = 0; p < NPART; p++)
      for (int a = 0; a < 32; a++) wr_state(p, a, '0);

    repeat (3) @(negedge clk);
    check(hit_valid == 1'b0, "R1 output quiet in reset", hit_valid, 0);
    // Program: dog / do+letter / cab (folded) / x+digit / b..y run / dog as whole word.
    wr_state(0, 1, sw("o", 2'd0, 2, 1, 1, 1, 0, 8'h00));
    wr_state(0, 2, sw("g", 2'd0, 0, 1, 5, 1, 1, 8'h51));
    wr_state(1, 1, sw(8'd1, 2'd2, 0, 0, 0, 0, 1, 8'h22));
    wr_state(2, 1, sw("a", 2'd1, 2, 0, 0, 0, 0, 8'h00));
    wr_state(2, 2, sw("b", 2'd1, 0, 0, 0, 0, 1, 8'h33));
    wr_state(3, 1, sw(8'd0, 2'd2, 0, 0, 0, 0, 1, 8'h40));
    wr_state(4, 1, sw("y", 2'd3, 1, 0, 0, 0, 1, 8'h66));
    wr_state(5, 1, sw(8'd2, 2'd2, 0, 0, 0, 0, 1, 8'h77));
    wr_start("d", 0, 1, 1);
    wr_start("c", 2, 1, 1);
    wr_start("C", 2, 1, 1);
    wr_start("x", 3, 1, 1);
    wr_start("b", 4, 1, 1);

    rst = 1'b0;
    @(negedge clk);
    check(hit_valid == 1'b0, "R1 output quiet after reset", hit_valid, 0);

    cur_tag = "R2"; send_str("dog "); drained("R2 start at first char after reset R7");
    cur_tag = "R3"; send_str("dot. do "); drained("R3 miss drops to idle");
    cur_tag = "R4"; send_str("CAB cAb cax "); drained("R4 fold mode");
    cur_tag = "R4"; send_str("x7 xa x "); drained("R4 class mode");
    cur_tag = "R4"; send_str("baby-byy bb "); drained("R4 run mode");
    cur_tag = "R2"; send_str("adog Bay og "); drained("R2 no start mid-word or unlisted");
    cur_tag = "R9"; send_str("dog-dog.dog7 dog"); send_char("%"); drained("R9 delimiter set");
    cur_tag = "R8";
    send_char("d"); gap(3); send_char("o"); gap(2); send_char("g"); gap(4); send_char(" ");
    drained("R8 idle cycles ignored");
    cur_tag = "R6"; send_str("dogs "); drained("R6 terminal reports");

    cur_tag = "R7";
    for (int k = 0; k < 1500; k++) begin
      if ($urandom_range(0, 1) == 0) send_str(words[$urandom_range(0, 11)]);
      else send_char(alph[$urandom_range(0, alph.len() - 1)]);
      if ($urandom_range(0, 2) == 0) send_char(seps[$urandom_range(0, 2)]);
      if ($urandom_range(0, 4) == 0) gap($urandom_range(1, 3));
    end
    send_char(" ");
    drained("R7 random stream");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule